// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is a station-management master for the two-wire PHY management bus. It generates the management clock (MDC) from the system clock and drives a bidirectional data line (MDIO) through a data output and an output enable. The host side asks for a PHY register access with a single-cycle request. The request carries a read or write select, a Clause 45 flag, a 5-bit PHY address, a register address and 16 bits of write data. When the access has finished, the block returns a one-cycle done pulse, the read data and a turnaround-error flag.

For a Clause 22 access the block sends one frame. For a Clause 45 access it splits the 21-bit address: bits 20:16 are the device address and bits 15:0 are the register number. It then sends two frames back to back. The first is an address frame that carries the register number. The second is the read or write frame addressed to the same device.

On a read, the block checks the turnaround bit that the PHY returns. A PHY that fails to pull this bit low is handled in one of two ways. If the PHY's bit in a 32-bit ignore mask is set, the fault is ignored. Otherwise the block flushes 32 clocks and reports all ones.

Top module: `mdio_master`

## Requirements
- R1: After reset and whenever no access is in progress, MDC is low, the output enable is low, and busy and done are low.
- R2: Every frame starts with 32 driven 1 bits. These are followed by a 2-bit start code and a 2-bit opcode. For Clause 22 the start code is 01, the read opcode is 10 and the write opcode is 01.
- R3: After the opcode, the master sends the 5-bit PHY address and then the 5-bit register or device address, each MSB first.
- R4: In write and address frames, the master drives the turnaround as 1 then 0. It then sends 16 data bits MSB first, releases MDIO for one more MDC period, and finishes. The frame is 65 MDC periods long.
- R5: In a read frame, MDIO is released right after the register field, and bit 46 is sampled as the turnaround. If that bit is 0, the next 16 bits are captured MSB first into the read data. One trailing released clock follows, and then done is raised with the error flag clear. The frame is 64 MDC periods long.
- R6: A read whose turnaround bit is 1, from a PHY whose bit in the ignore mask is clear, produces 32 extra released clocks. The frame is 79 periods in total, and done comes with read data 0xFFFF and the error flag set.
- R7: If the PHY's bit in the ignore mask is set, a turnaround bit of 1 has no effect. The data is captured normally, the frame is 64 periods long and the error flag stays clear.
- R8: A Clause 45 access sends two frames. The first uses start code 00 and opcode 00, carries the device address (address bits 20:16) in the register field and carries address bits 15:0 as data. The second uses start 00 and opcode 11 (read) or 01 (write) to the same device.
- R9: Each high half and each low half of MDC lasts the parameter HALF_CYC in system-clock cycles.
- R10: The data output changes only in the system-clock cycle in which MDC goes low or while MDC is low. It never changes while MDC is high.
- R11: Read bits are sampled in the last system-clock cycle of the MDC high half. A value that the PHY corrects one cycle before MDC falls is still captured correctly.
- R12: A start is accepted only when idle, and busy rises in the following cycle. A start given while busy is ignored. Done is a single-cycle pulse in the cycle in which busy falls.
- R13: With the parameter PULLUP_OUT at 1, the data output is held at 1 whenever the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Access request, sampled only when idle |
| read_i | input | 1 | 1 = read, 0 = write |
| c45_i | input | 1 | 1 = Clause 45 two-frame access |
| phy_addr_i | input | 5 | PHY address |
| reg_addr_i | input | 21 | Register address; bits 4:0 used for Clause 22, bits 20:16 device and 15:0 register for Clause 45 |
| wdata_i | input | 16 | Write data |
| ta_ignore_mask_i | input | 32 | One bit per PHY address; a set bit ignores a bad read turnaround |
| mdio_i | input | 1 | Sampled MDIO line |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read data, valid with done |
| ta_err_o | output | 1 | Turnaround error, valid with done |

## Verification
The bench builds the block with HALF_CYC at 4, the preamble and flush lengths at their protocol value of 32, and PULLUP_OUT at 1. With these values a full Clause 45 read of 129 MDC periods takes about a thousand system cycles, so every frame shape fits in a short run: write, good read, flushed read, masked read and both Clause 45 sequences. The short half period still leaves room for the PHY model to present a wrong bit early in the high half and correct it one cycle before the fall, which exposes any sampling point that is too early.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;

   localparam int PHY_W   = 5;
   localparam int REG_W   = 5;
   localparam int DATA_W  = 16;
   localparam int XADDR_W = 21;
   localparam int NPHY    = 1 << PHY_W;

   // Frame field codes
   localparam logic [1:0] ST_C22    = 2'b01;
   localparam logic [1:0] ST_C45    = 2'b00;
   localparam logic [1:0] OP22_RD   = 2'b10;
   localparam logic [1:0] OP22_WR   = 2'b01;
   localparam logic [1:0] OP45_ADR  = 2'b00;
   localparam logic [1:0] OP45_RD   = 2'b11;
   localparam logic [1:0] OP45_WR   = 2'b01;
   localparam logic [1:0] TA_DRIVEN = 2'b10;

   typedef enum logic [2:0] {
      EN_IDLE,
      EN_TX,
      EN_TA,
      EN_RX,
      EN_TAIL,
      EN_FLUSH
   } eng_state_t;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_ADDR,
      SQ_ACC
   } seq_state_t;

   // One frame as handed from sequencer to frame engine
   typedef struct packed {
      logic [1:0]        st;
      logic [1:0]        op;
      logic [PHY_W-1:0]  phy;
      logic [REG_W-1:0]  regad;
      logic [DATA_W-1:0] data;
      logic              rd;
      logic              ta_skip;
   } frame_req_t;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
   parameter int HALF_CYC = 50
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   output logic mdc_o,
   output logic rise_o,
   output logic fall_o
);

   localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

   logic [CW-1:0] cnt_q;
   logic          wrap;

   assign wrap   = run_i && (cnt_q == LAST);
   assign rise_o = wrap && !mdc_o;
   assign fall_o = wrap && mdc_o;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         mdc_o <= 1'b0;
      end else if (!run_i) begin
         cnt_q <= '0;
         mdc_o <= 1'b0;
      end else if (wrap) begin
         cnt_q <= '0;
         mdc_o <= ~mdc_o;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // Independent length measurement of the high half
   int high_len_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) high_len_q <= 0;
      else         high_len_q <= mdc_o ? high_len_q + 1 : 0;
   end

   AST_HIGH_HALF_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(mdc_o) |-> high_len_q == HALF_CYC); // R9

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
   import mdio_master_pkg::*;
#(
   parameter int PRE_LEN   = 32,
   parameter int FLUSH_LEN = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              go_i,
   input  frame_req_t        req_i,
   input  logic              fall_i,
   input  logic              mdio_i,
   output logic              run_o,
   output logic              oe_o,
   output logic              bit_o,
   output logic              done_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              ta_err_o
);

   localparam int HDR_W  = 2 + 2 + PHY_W + REG_W;
   localparam int TX_W   = PRE_LEN + HDR_W + 2 + DATA_W;
   localparam int CNT_MAX = (TX_W > FLUSH_LEN) ? TX_W : FLUSH_LEN;
   localparam int CNT_W  = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(PRE_LEN + HDR_W - 1);
   localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(TX_W - 1);
   localparam logic [CNT_W-1:0] RX_LAST = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] FL_LAST = CNT_W'(FLUSH_LEN - 1);

   eng_state_t        state_q;
   logic [TX_W-1:0]   tx_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  last_q;
   logic [DATA_W-1:0] rx_q;
   logic              err_q, oe_q, run_q, done_q, rd_q, skip_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= EN_IDLE;
         tx_q    <= '0;
         cnt_q   <= '0;
         last_q  <= '0;
         rx_q    <= '0;
         err_q   <= 1'b0;
         oe_q    <= 1'b0;
         run_q   <= 1'b0;
         done_q  <= 1'b0;
         rd_q    <= 1'b0;
         skip_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            EN_IDLE: begin
               if (go_i) begin
                  tx_q    <= {{PRE_LEN{1'b1}}, req_i.st, req_i.op, req_i.phy,
                              req_i.regad, TA_DRIVEN, req_i.data};
                  cnt_q   <= '0;
                  last_q  <= req_i.rd ? RD_LAST : WR_LAST;
                  rd_q    <= req_i.rd;
                  skip_q  <= req_i.ta_skip;
                  rx_q    <= '0;
                  err_q   <= 1'b0;
                  oe_q    <= 1'b1;
                  run_q   <= 1'b1;
                  state_q <= EN_TX;
               end
            end
            EN_TX: begin
               if (fall_i) begin
                  tx_q <= tx_q << 1;
                  if (cnt_q == last_q) begin
                     cnt_q   <= '0;
                     oe_q    <= 1'b0;
                     state_q <= rd_q ? EN_TA : EN_TAIL;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            EN_TA: begin
               if (fall_i) begin
                  cnt_q <= '0;
                  if (!mdio_i || skip_q) begin
                     state_q <= EN_RX;
                  end else begin
                     err_q   <= 1'b1;
                     rx_q    <= '1;
                     state_q <= EN_FLUSH;
                  end
               end
            end
            EN_RX: begin
               if (fall_i) begin
                  rx_q <= {rx_q[DATA_W-2:0], mdio_i};
                  if (cnt_q == RX_LAST) begin
                     cnt_q   <= '0;
                     state_q <= EN_TAIL;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            EN_TAIL: begin
               if (fall_i) begin
                  run_q   <= 1'b0;
                  done_q  <= 1'b1;
                  state_q <= EN_IDLE;
               end
            end
            EN_FLUSH: begin
               if (fall_i) begin
                  if (cnt_q == FL_LAST) begin
                     cnt_q   <= '0;
                     run_q   <= 1'b0;
                     done_q  <= 1'b1;
                     state_q <= EN_IDLE;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            default: state_q <= EN_IDLE;
         endcase
      end
   end

   assign run_o    = run_q;
   assign oe_o     = oe_q;
   assign bit_o    = tx_q[TX_W-1];
   assign done_o   = done_q;
   assign rdata_o  = rx_q;
   assign ta_err_o = err_q;

   AST_FLUSH_ALL_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q && err_q |-> rx_q == '1); // R6

   AST_OE_WITHIN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      oe_q |-> run_q); // R1

   AST_TX_MOVES_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(tx_q[TX_W-1]) |-> $past(fall_i) || $past(state_q == EN_IDLE)); // R10

   AST_TA_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_q == EN_TA |-> !oe_q); // R5

endmodule

// File: rtl/mdio_req_seq.sv
module mdio_req_seq
   import mdio_master_pkg::*;
(
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               start_i,
   input  logic               read_i,
   input  logic               c45_i,
   input  logic [PHY_W-1:0]   phy_i,
   input  logic [XADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0]  wdata_i,
   input  logic [NPHY-1:0]    ign_mask_i,
   input  logic               frame_done_i,
   input  logic [DATA_W-1:0]  frame_rdata_i,
   input  logic               frame_err_i,
   output logic               go_o,
   output frame_req_t         req_o,
   output logic               busy_o,
   output logic               done_o,
   output logic [DATA_W-1:0]  rdata_o,
   output logic               ta_err_o
);

   seq_state_t        state_q;
   frame_req_t        req_q;
   logic              go_q, busy_q, done_q, err_q, rd_q;
   logic [DATA_W-1:0] wd_q, rdata_q;
   logic              skip;

   assign skip = ign_mask_i[phy_i];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= SQ_IDLE;
         req_q   <= '0;
         go_q    <= 1'b0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         rd_q    <= 1'b0;
         wd_q    <= '0;
         rdata_q <= '0;
      end else begin
         go_q   <= 1'b0;
         done_q <= 1'b0;
         unique case (state_q)
            SQ_IDLE: begin
               if (start_i) begin
                  busy_q <= 1'b1;
                  go_q   <= 1'b1;
                  rd_q   <= read_i;
                  wd_q   <= wdata_i;
                  if (c45_i) begin
                     req_q <= '{st: ST_C45, op: OP45_ADR, phy: phy_i,
                                regad: addr_i[XADDR_W-1:DATA_W],
                                data: addr_i[DATA_W-1:0], rd: 1'b0, ta_skip: skip};
                     state_q <= SQ_ADDR;
                  end else begin
                     req_q <= '{st: ST_C22, op: (read_i ? OP22_RD : OP22_WR),
                                phy: phy_i, regad: addr_i[REG_W-1:0],
                                data: wdata_i, rd: read_i, ta_skip: skip};
                     state_q <= SQ_ACC;
                  end
               end
            end
            SQ_ADDR: begin
               if (frame_done_i) begin
                  go_q       <= 1'b1;
                  req_q.op   <= rd_q ? OP45_RD : OP45_WR;
                  req_q.data <= wd_q;
                  req_q.rd   <= rd_q;
                  state_q    <= SQ_ACC;
               end
            end
            SQ_ACC: begin
               if (frame_done_i) begin
                  done_q  <= 1'b1;
                  busy_q  <= 1'b0;
                  rdata_q <= frame_rdata_i;
                  err_q   <= frame_err_i;
                  state_q <= SQ_IDLE;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign go_o     = go_q;
   assign req_o    = req_q;
   assign busy_o   = busy_q;
   assign done_o   = done_q;
   assign rdata_o  = rdata_q;
   assign ta_err_o = err_q;

   AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |=> !done_q); // R12

   AST_BUSY_FROM_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_q) |-> $past(start_i)); // R12

   AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |-> !busy_q && $past(busy_q)); // R12

endmodule

// File: rtl/mdio_pad_drv.sv
module mdio_pad_drv #(
   parameter bit PULLUP_OUT = 1'b1
) (
   input  logic oe_i,
   input  logic bit_i,
   output logic mdio_o,
   output logic mdio_oe_o
);

   assign mdio_oe_o = oe_i;

   generate
      if (PULLUP_OUT) begin : g_pullup
         assign mdio_o = oe_i ? bit_i : 1'b1;
      end else begin : g_plain
         assign mdio_o = oe_i & bit_i;
      end
   endgenerate

endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_master_pkg::*;
#(
   parameter int HALF_CYC   = 50,
   parameter int PRE_LEN    = 32,
   parameter int FLUSH_LEN  = 32,
   parameter bit PULLUP_OUT = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               start_i,
   input  logic               read_i,
   input  logic               c45_i,
   input  logic [4:0]         phy_addr_i,
   input  logic [20:0]        reg_addr_i,
   input  logic [15:0]        wdata_i,
   input  logic [31:0]        ta_ignore_mask_i,
   input  logic               mdio_i,
   output logic               mdc_o,
   output logic               mdio_o,
   output logic               mdio_oe_o,
   output logic               busy_o,
   output logic               done_o,
   output logic [15:0]        rdata_o,
   output logic               ta_err_o
);

   generate
      if (HALF_CYC < 2) begin : g_bad_half
         $error("HALF_CYC must be at least 2");
      end
      if (PRE_LEN < 1) begin : g_bad_pre
         $error("PRE_LEN must be at least 1");
      end
      if (FLUSH_LEN < 1) begin : g_bad_flush
         $error("FLUSH_LEN must be at least 1");
      end
   endgenerate

   frame_req_t        req;
   logic              go, run, rise, fall, oe, tx_bit;
   logic              f_done, f_err;
   logic [DATA_W-1:0] f_rdata;

   mdio_req_seq u_seq (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .start_i       (start_i),
      .read_i        (read_i),
      .c45_i         (c45_i),
      .phy_i         (phy_addr_i),
      .addr_i        (reg_addr_i),
      .wdata_i       (wdata_i),
      .ign_mask_i    (ta_ignore_mask_i),
      .frame_done_i  (f_done),
      .frame_rdata_i (f_rdata),
      .frame_err_i   (f_err),
      .go_o          (go),
      .req_o         (req),
      .busy_o        (busy_o),
      .done_o        (done_o),
      .rdata_o       (rdata_o),
      .ta_err_o      (ta_err_o)
   );

   mdio_frame_engine #(
      .PRE_LEN   (PRE_LEN),
      .FLUSH_LEN (FLUSH_LEN)
   ) u_eng (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .go_i     (go),
      .req_i    (req),
      .fall_i   (fall),
      .mdio_i   (mdio_i),
      .run_o    (run),
      .oe_o     (oe),
      .bit_o    (tx_bit),
      .done_o   (f_done),
      .rdata_o  (f_rdata),
      .ta_err_o (f_err)
   );

   mdio_mdc_gen #(
      .HALF_CYC (HALF_CYC)
   ) u_clk (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run),
      .mdc_o  (mdc_o),
      .rise_o (rise),
      .fall_o (fall)
   );

   mdio_pad_drv #(
      .PULLUP_OUT (PULLUP_OUT)
   ) u_pad (
      .oe_i      (oe),
      .bit_i     (tx_bit),
      .mdio_o    (mdio_o),
      .mdio_oe_o (mdio_oe_o)
   );

   AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> !mdc_o && !mdio_oe_o); // R1

   AST_HELD_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise |=> $stable(mdio_o)); // R10

   AST_RELEASED_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !mdio_oe_o |-> (mdio_o || !PULLUP_OUT)); // R13

endmodule

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;

   localparam int HALF = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, rd = 1'b0, c45 = 1'b0;
   logic [4:0]  phy = '0;
   logic [20:0] addr = '0;
   logic [15:0] wdata = '0;
   logic [31:0] mask = '0;
   logic        mdio_in = 1'b1;
   logic        mdc, mo, oe, busy, done, err;
   logic [15:0] rdata;

   always #2.5 clk = ~clk;

   mdio_master #(.HALF_CYC(HALF), .PRE_LEN(32), .FLUSH_LEN(32), .PULLUP_OUT(1'b1)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .read_i(rd), .c45_i(c45),
      .phy_addr_i(phy), .reg_addr_i(addr), .wdata_i(wdata),
      .ta_ignore_mask_i(mask), .mdio_i(mdio_in), .mdc_o(mdc), .mdio_o(mo),
      .mdio_oe_o(oe), .busy_o(busy), .done_o(done), .rdata_o(rdata), .ta_err_o(err));

   int nchk = 0, nbad = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // PHY-side model: record master bits at each MDC rise, answer with resp[]
   logic rec_oe [0:255];
   logic rec_out[0:255];
   logic resp   [0:255];
   int   nrise = 0;
   bit   late_mode = 0;

   always @(posedge mdc) begin
      int k;
      k = nrise;
      nrise = k + 1;
      if (k < 256) begin
         rec_oe[k]  = oe;
         rec_out[k] = mo;
         if (late_mode) begin
            mdio_in = ~resp[k];
            repeat (HALF - 1) @(posedge clk);
            mdio_in = resp[k];
         end else begin
            mdio_in = resp[k];
         end
      end
   end

   // Timing monitors (R9, R10)
   int  hr = 0, hw_seen = 0, hw_bad = 0, r10_bad = 0;
   logic prev_mdc = 1'b0, prev_o = 1'b1;
   always @(negedge clk) begin
      if (rst_n) begin
         if (mdc) hr++;
         else if (prev_mdc) begin
            hw_seen++;
            if (hr != HALF) hw_bad++;
            hr = 0;
         end
         if (mdc && mo !== prev_o) r10_bad++;
      end
      prev_mdc = mdc;
      prev_o   = mo;
   end

   function automatic logic [63:0] mkframe(logic [1:0] st, logic [1:0] op,
                                           logic [4:0] p, logic [4:0] r, logic [15:0] d);
      return {32'hFFFF_FFFF, st, op, p, r, 2'b10, d};
   endfunction

   function automatic int mism(int base, int lo, int hi, logic [63:0] exp);
      int m = 0;
      for (int i = lo; i <= hi; i++)
         if (rec_oe[base+i] !== 1'b1 || rec_out[base+i] !== exp[63-i]) m++;
      return m;
   endfunction

   function automatic int released_bad(int base, int lo, int hi);
      int m = 0;
      for (int i = lo; i <= hi; i++)
         if (rec_oe[base+i] !== 1'b0 || rec_out[base+i] !== 1'b1) m++;
      return m;
   endfunction

   task automatic prep(input int base, input logic ta, input logic [15:0] d);
      for (int i = 0; i < 256; i++) resp[i] = 1'b1;
      resp[base+46] = ta;
      for (int j = 0; j < 16; j++) resp[base+47+j] = d[15-j];
      nrise = 0;
   endtask

   task automatic go(input logic r, input logic x, input logic [4:0] p,
                     input logic [20:0] a, input logic [15:0] d);
      @(negedge clk);
      rd = r; c45 = x; phy = p; addr = a; wdata = d; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(input string req);
      bit got = 0;
      for (int i = 0; i < 20000; i++) begin
         if (done) begin got = 1; break; end
         @(negedge clk);
      end
      chk(got, req, "done seen", got, 1);
   endtask

   task automatic t_reset;
      chk(mdc == 1'b0 && oe == 1'b0, "R1", "mdc/oe after reset", {mdc, oe}, 0);
      chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done after reset", {busy, done}, 0);
      chk(mo == 1'b1, "R13", "released output high", mo, 1);
   endtask

   task automatic t_c22_write;
      logic [63:0] f;
      f = mkframe(2'b01, 2'b01, 5'h13, 5'h0A, 16'hA5C3);
      prep(0, 1'b1, 16'h0);
      go(1'b0, 1'b0, 5'h13, 21'h0000A, 16'hA5C3);
      wait_done("R4");
      chk(nrise == 65, "R4", "write frame length", nrise, 65);
      chk(mism(0, 0, 31, f) == 0, "R2", "preamble", mism(0, 0, 31, f), 0);
      chk(mism(0, 32, 35, f) == 0, "R2", "c22 write start/op", mism(0, 32, 35, f), 0);
      chk(mism(0, 36, 45, f) == 0, "R3", "phy/reg fields", mism(0, 36, 45, f), 0);
      chk(mism(0, 46, 63, f) == 0, "R4", "ta and data", mism(0, 46, 63, f), 0);
      chk(released_bad(0, 64, 64) == 0, "R4", "trailing released clock", released_bad(0, 64, 64), 0);
      @(negedge clk);
      chk(!busy && !mdc && !oe, "R1", "quiet after access", {busy, mdc, oe}, 0);
   endtask

   task automatic t_c22_read(input bit late);
      logic [63:0] f;
      f = mkframe(2'b01, 2'b10, 5'h07, 5'h1F, 16'h0);
      prep(0, 1'b0, 16'h9E21);
      late_mode = late;
      go(1'b1, 1'b0, 5'h07, 21'h0001F, 16'hFFFF);
      wait_done(late ? "R11" : "R5");
      late_mode = 0;
      if (late) begin
         chk(rdata == 16'h9E21, "R11", "late-corrected read data", rdata, 16'h9E21);
      end else begin
         chk(nrise == 64, "R5", "read frame length", nrise, 64);
         chk(mism(0, 0, 45, f) == 0, "R2", "c22 read header", mism(0, 0, 45, f), 0);
         chk(released_bad(0, 46, 63) == 0, "R13", "released bits high", released_bad(0, 46, 63), 0);
         chk(rdata == 16'h9E21 && err == 1'b0, "R5", "read data/err", {err, rdata}, 16'h9E21);
      end
   endtask

   task automatic t_bad_ta;
      mask = 32'hFFFF_FFFE;  // PHY 0 bit clear
      prep(0, 1'b1, 16'h1234);
      go(1'b1, 1'b0, 5'h00, 21'h00002, 16'h0);
      wait_done("R6");
      chk(nrise == 79, "R6", "flush frame length", nrise, 79);
      chk(rdata == 16'hFFFF && err == 1'b1, "R6", "flush data/err", {err, rdata}, 17'h1FFFF);
      mask = '0;
   endtask

   task automatic t_masked;
      mask = 32'h0000_0200;  // PHY 9 ignores turnaround
      prep(0, 1'b1, 16'h1234);
      go(1'b1, 1'b0, 5'h09, 21'h00003, 16'h0);
      wait_done("R7");
      chk(nrise == 64, "R7", "masked frame length", nrise, 64);
      chk(rdata == 16'h1234 && err == 1'b0, "R7", "masked data/err", {err, rdata}, 16'h1234);
      mask = '0;
   endtask

   task automatic t_c45(input logic r);
      logic [63:0] fa, fb;
      fa = mkframe(2'b00, 2'b00, 5'h11, 5'h1E, 16'hBEEF);
      fb = mkframe(2'b00, r ? 2'b11 : 2'b01, 5'h11, 5'h1E, r ? 16'h0 : 16'h5A0F);
      prep(65, 1'b0, 16'hC0DE);
      go(r, 1'b1, 5'h11, 21'h1E_BEEF, 16'h5A0F);
      wait_done("R8");
      chk(nrise == (r ? 129 : 130), "R8", "c45 total length", nrise, r ? 129 : 130);
      chk(mism(0, 0, 63, fa) == 0, "R8", "c45 address frame", mism(0, 0, 63, fa), 0);
      if (r) begin
         chk(mism(65, 0, 45, fb) == 0, "R8", "c45 read header", mism(65, 0, 45, fb), 0);
         chk(rdata == 16'hC0DE && err == 1'b0, "R8", "c45 read data", {err, rdata}, 16'hC0DE);
      end else begin
         chk(mism(65, 0, 63, fb) == 0, "R8", "c45 write frame", mism(65, 0, 63, fb), 0);
      end
   endtask

   task automatic t_busy;
      int dcount = 0;
      prep(0, 1'b1, 16'h0);
      go(1'b0, 1'b0, 5'h01, 21'h00002, 16'h00FF);
      chk(busy == 1'b1, "R12", "busy after accepted start", busy, 1);
      repeat (30) @(negedge clk);
      go(1'b1, 1'b1, 5'h02, 21'h1F_0000, 16'h0);  // must be ignored
      wait_done("R12");
      chk(!busy, "R12", "busy low with done", busy, 0);
      @(negedge clk);
      chk(!done, "R12", "done single cycle", done, 0);
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (done) dcount++;
      end
      chk(nrise == 65 && dcount == 0, "R12", "start while busy ignored", nrise, 65);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_c22_write();
      t_c22_read(1'b0);
      t_c22_read(1'b1);
      t_bad_ta();
      t_masked();
      t_c45(1'b1);
      t_c45(1'b0);
      t_busy();
      chk(hw_seen > 0 && hw_bad == 0, "R9", "mdc high half length", hw_bad, 0);
      chk(r10_bad == 0, "R10", "data change while mdc high", r10_bad, 0);
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         finished = 1;
         nchk++;
         nbad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end

endmodule